// File: doc/BRIEF.md
# Double-Buffered Parallel-to-Serial Configuration Loader

This block takes configuration bytes from a processor-style parallel write port and sends them out one bit at a time on a single serial line. A divider generates a free-running serial clock `sclk`. The block holds two bytes at most:

- a holding register that captures each written byte;
- a shift stage that presents the bits of the byte in progress.

A byte therefore waits in the holding register while the previous byte is still leaving.

The processor watches `busy` and writes the next byte as soon as `busy` drops. The time `busy` stays high varies with the state of the shift stage and with the divider phase at the moment of the write:

- It is short when the shift stage is empty.
- It is long when the shift stage has only just taken a byte.

A write made while `busy` is high is dropped, and the drop is remembered on a sticky flag.

Top module: `cfg_serial_loader`

## Requirements
- R1: A synchronous active-high `rst` clears both storage levels and drives the outputs to `busy`=0, `overrun`=0, `sdout`=1 and `sclk`=0.
- R2: A write is live only while `sel0_n`=0, `sel1_n`=0, `sel_hi`=1 and `wr_n`=0 all hold together. A strobe with any select inactive is ignored: `busy` stays low, no bits appear on `sdout`, and `overrun` stays low.
- R3: The byte is taken from `din` as it was in the last cycle of the live write. `din` may change in the same cycle the strobe ends. `busy` is high in the first cycle after the strobe ends.
- R4: `sclk` is a continuous square wave with period 2*HALF_DIV system clocks, high for HALF_DIV clocks and low for HALF_DIV clocks.
- R5: Each byte leaves as DATA_W consecutive `sclk` periods, most significant bit first. `sdout` changes only in the cycle where `sclk` falls, so it is steady at each rising `sclk`. `sdout` is 1 when no byte is in progress.
- R6: A byte written while the shift stage is empty moves into it at the next falling `sclk`. `busy` therefore lasts at most one `sclk` period.
- R7: A byte written just after the shift stage took a byte keeps `busy` high until that byte has been fully sent. This is more than DATA_W-1 and at most DATA_W `sclk` periods.
- R8: A byte waiting in the holding register starts on the falling `sclk` right after the last bit of the previous byte. No idle bit is placed between the two bytes.
- R9: A write that ends while `busy` is high is dropped and sets `overrun`. `overrun` stays set until reset.
- R10: A new write may begin in the very cycle `busy` is seen low and is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel0_n | input | 1 | Low-active select, first |
| sel1_n | input | 1 | Low-active select, second |
| sel_hi | input | 1 | High-active select |
| wr_n | input | 1 | Low-active write strobe |
| din | input | DATA_W | Parallel write data |
| busy | output | 1 | High while the holding register is occupied |
| overrun | output | 1 | Sticky flag for a dropped write |
| sclk | output | 1 | Free-running serial clock |
| sdout | output | 1 | Serial data, MSB first, stable at rising `sclk` |

## Verification
The bench builds the block with DATA_W=8 and HALF_DIV=3, which makes one `sclk` period six system clocks. At that ratio a byte shifts out in 48 cycles, so several hundred bytes of random traffic fit easily in the run. Both busy bounds, the short one for an empty shift stage and the long one for a just-loaded stage, sit only a few cycles from their limits and can be measured exactly.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;
  typedef enum logic {SH_EMPTY = 1'b0, SH_RUN = 1'b1} sh_state_t;

  function automatic int cnt_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/cfgl_clkgen.sv
module cfgl_clkgen #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic sclk,
  output logic fall_tick
);
  localparam int CW = cfgl_pkg::cnt_w(HALF_DIV);
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          sclk_q;
  logic          wrap;

  assign wrap      = (cnt_q == LAST);
  assign fall_tick = wrap & sclk_q;
  assign sclk      = sclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      if (wrap) sclk_q <= ~sclk_q;
    end
  end

  a_r4_cnt_range: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
  a_r4_half_steady: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != LAST) |=> $stable(sclk_q));
endmodule

// File: rtl/cfgl_wr_decode.sv
module cfgl_wr_decode #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel0_n,
  input  logic              sel1_n,
  input  logic              sel_hi,
  input  logic              wr_n,
  input  logic [DATA_W-1:0] din,
  output logic              wr_evt,
  output logic [DATA_W-1:0] wr_data
);
  logic              live;
  logic              live_q;
  logic [DATA_W-1:0] data_q;

  assign live    = ~sel0_n & ~sel1_n & sel_hi & ~wr_n;
  assign wr_evt  = live_q & ~live;
  assign wr_data = data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q <= 1'b0;
      data_q <= '0;
    end else begin
      live_q <= live;
      if (live) data_q <= din;
    end
  end

  a_r2_evt_needs_live: assert property (@(posedge clk) disable iff (rst)
    wr_evt |-> $past(~sel0_n & ~sel1_n & sel_hi & ~wr_n));
endmodule

// File: rtl/cfgl_buffer.sv
module cfgl_buffer #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_evt,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              fall_tick,
  output logic              busy,
  output logic              overrun,
  output logic              sdout
);
  import cfgl_pkg::*;
  localparam int BW = cnt_w(DATA_W);
  localparam logic [BW-1:0] LOAD_LEFT = BW'(DATA_W - 1);

  logic [DATA_W-1:0] hold_q;
  logic              hold_full;
  logic [DATA_W-1:0] sh_q;
  logic [BW-1:0]     left_q;
  sh_state_t         sh_st;
  logic              ovr_q;
  logic              sdo_q;

  assign busy    = hold_full;
  assign overrun = ovr_q;
  assign sdout   = sdo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q    <= '0;
      hold_full <= 1'b0;
      sh_q      <= '0;
      left_q    <= '0;
      sh_st     <= SH_EMPTY;
      ovr_q     <= 1'b0;
      sdo_q     <= 1'b1;
    end else begin
      if (wr_evt) begin
        if (!hold_full) begin
          hold_q    <= wr_data;
          hold_full <= 1'b1;
        end else begin
          ovr_q <= 1'b1;
        end
      end
      if (fall_tick) begin
        if (sh_st == SH_RUN) begin
          sdo_q  <= sh_q[DATA_W-1];
          sh_q   <= sh_q << 1;
          left_q <= left_q - 1'b1;
          if (left_q == BW'(1)) sh_st <= SH_EMPTY;
        end else if (hold_full) begin
          sdo_q     <= hold_q[DATA_W-1];
          sh_q      <= hold_q << 1;
          left_q    <= LOAD_LEFT;
          sh_st     <= (DATA_W > 1) ? SH_RUN : SH_EMPTY;
          hold_full <= 1'b0;
        end else begin
          sdo_q <= 1'b1;
        end
      end
    end
  end

  a_r5_sdout_on_fall: assert property (@(posedge clk) disable iff (rst)
    !fall_tick |=> $stable(sdo_q));
  a_r6_busy_drops_on_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(hold_full) |-> $past(fall_tick));
  a_r3_busy_rises_on_write: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_full) |-> $past(wr_evt));
  a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
    ovr_q |=> ovr_q);
  a_r5_left_range: assert property (@(posedge clk) disable iff (rst)
    left_q <= LOAD_LEFT);
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader #(
  parameter int DATA_W   = 8,
  parameter int HALF_DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel0_n,
  input  logic              sel1_n,
  input  logic              sel_hi,
  input  logic              wr_n,
  input  logic [DATA_W-1:0] din,
  output logic              busy,
  output logic              overrun,
  output logic              sclk,
  output logic              sdout
);
  logic              fall_tick;
  logic              wr_evt;
  logic [DATA_W-1:0] wr_data;

  cfgl_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
    .clk(clk), .rst(rst), .sclk(sclk), .fall_tick(fall_tick)
  );

  cfgl_wr_decode #(.DATA_W(DATA_W)) u_decode (
    .clk(clk), .rst(rst), .sel0_n(sel0_n), .sel1_n(sel1_n),
    .sel_hi(sel_hi), .wr_n(wr_n), .din(din),
    .wr_evt(wr_evt), .wr_data(wr_data)
  );

  cfgl_buffer #(.DATA_W(DATA_W)) u_buffer (
    .clk(clk), .rst(rst), .wr_evt(wr_evt), .wr_data(wr_data),
    .fall_tick(fall_tick), .busy(busy), .overrun(overrun), .sdout(sdout)
  );
endmodule

// File: tb/cfg_serial_loader_bench.sv
module cfg_serial_loader_bench;
  localparam int W = 8;
  localparam int HD = 3;
  localparam int P = 2 * HD;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel0_n = 1'b1, sel1_n = 1'b1, sel_hi = 1'b0, wr_n = 1'b1;
  logic [W-1:0] din = '0;
  logic busy, overrun, sclk, sdout;

  int total = 0, bad = 0, cyc = 0, popped = 0, accepted = 0;
  logic [W-1:0] acc_q[$];
  bit exp_bits[$];

  cfg_serial_loader #(.DATA_W(W), .HALF_DIV(HD)) u_cfg_serial_loader (
    .clk(clk), .rst(rst), .sel0_n(sel0_n), .sel1_n(sel1_n), .sel_hi(sel_hi),
    .wr_n(wr_n), .din(din), .busy(busy), .overrun(overrun),
    .sclk(sclk), .sdout(sdout)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(1'b0, "watchdog", cyc, 150000);
      finish_run();
    end
  end

  // Byte leaves the holding register when busy falls: queue its bits, MSB first (R5)
  always @(negedge busy) begin
    if (!rst && acc_q.size() > 0) begin
      logic [W-1:0] b;
      b = acc_q.pop_front();
      for (int i = W - 1; i >= 0; i--) exp_bits.push_back(b[i]);
    end
  end

  // Stream monitor: R5 bit order and idle level, R8 no gap, R2/R9 no stray bytes
  always @(posedge sclk) begin
    if (!rst) begin
      if (exp_bits.size() > 0) begin
        bit e;
        e = exp_bits.pop_front();
        popped++;
        chk(sdout == e, "R5 R8 serial bit", sdout, e);
      end else begin
        chk(sdout == 1'b1, "R5 R2 R9 idle level", sdout, 1);
      end
    end
  end

  task automatic strobe(input logic [W-1:0] d, input int len,
                        input logic s0, input logic s1, input logic sh);
    sel0_n = s0; sel1_n = s1; sel_hi = sh; wr_n = 1'b0; din = d;
    repeat (len) @(negedge clk);
    wr_n = 1'b1; sel0_n = 1'b1; sel1_n = 1'b1; sel_hi = 1'b0;
    din = ~d;
  endtask

  task automatic wait_idle_busy();
    while (busy) @(negedge clk);
  endtask

  task automatic drain();
    while (busy || acc_q.size() > 0 || exp_bits.size() > 0) @(negedge clk);
    repeat (P) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  function automatic int rand_range(input int lo, input int hi);
    return lo + int'($urandom % (hi - lo + 1));
  endfunction

  initial begin
    int t0, t1, dur, hi_cnt;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 0, "R1 busy", busy, 0);
    chk(overrun == 0, "R1 overrun", overrun, 0);
    chk(sdout == 1, "R1 sdout", sdout, 1);
    chk(sclk == 0, "R1 sclk", sclk, 0);
    rst = 1'b0;

    // R4 sclk period and duty
    @(posedge sclk); t0 = cyc;
    @(negedge sclk); hi_cnt = cyc - t0;
    @(posedge sclk); t1 = cyc;
    chk(t1 - t0 == P, "R4 period", t1 - t0, P);
    chk(hi_cnt == HD, "R4 high time", hi_cnt, HD);

    // R2 each select inactive in turn
    @(negedge clk);
    strobe(8'h00, 2, 1'b1, 1'b0, 1'b1); @(negedge clk);
    chk(busy == 0, "R2 sel0 off", busy, 0);
    strobe(8'h11, 2, 1'b0, 1'b1, 1'b1); @(negedge clk);
    chk(busy == 0, "R2 sel1 off", busy, 0);
    strobe(8'h22, 2, 1'b0, 1'b0, 1'b0); @(negedge clk);
    chk(busy == 0, "R2 selhi off", busy, 0);
    repeat (2 * P) @(negedge clk);
    chk(overrun == 0, "R2 overrun", overrun, 0);

    // R3 + R6: write into empty stage, data changes as strobe ends
    acc_q.push_back(8'hA5); accepted++;
    strobe(8'hA5, 1, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    chk(busy == 1, "R3 busy after strobe", busy, 1);
    t0 = cyc;
    wait_idle_busy();
    dur = cyc - t0 + 1;
    chk(dur >= 1 && dur <= P, "R6 short busy", dur, P);

    // R10 + R7: next byte right away, it must wait the whole previous byte
    acc_q.push_back(8'h3C); accepted++;
    strobe(8'h3C, 1, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    chk(busy == 1, "R10 accepted at once", busy, 1);
    t0 = cyc;
    // R9 write while busy is dropped
    strobe(8'hFF, 2, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    chk(overrun == 1, "R9 overrun set", overrun, 1);
    chk(busy == 1, "R9 busy held", busy, 1);
    wait_idle_busy();
    dur = cyc - t0 + 1;
    chk(dur > (W - 1) * P && dur <= W * P, "R7 long busy", dur, W * P);
    drain();
    chk(overrun == 1, "R9 overrun sticky", overrun, 1);
    do_reset();
    @(negedge clk);
    chk(overrun == 0, "R1 overrun cleared", overrun, 0);

    // Random traffic, legal writes plus ignored strobes
    for (int n = 0; n < 200; n++) begin
      logic [W-1:0] d;
      d = W'($urandom);
      wait_idle_busy();
      repeat (rand_range(0, 2) == 0 ? 0 : rand_range(0, 10)) @(negedge clk);
      if (rand_range(0, 4) == 0) begin
        strobe(d, rand_range(1, 3), 1'b1, 1'b0, 1'b1);
        @(negedge clk);
        chk(busy == 0, "R2 random ignored", busy, 0);
      end
      wait_idle_busy();
      acc_q.push_back(d); accepted++;
      strobe(d, rand_range(1, 3), 1'b0, 1'b0, 1'b1);
      @(negedge clk);
      chk(busy == 1, "R3 random busy", busy, 1);
    end
    drain();
    chk(popped == accepted * W, "R5 bit count", popped, accepted * W);
    chk(overrun == 0, "R9 no overrun on legal traffic", overrun, 0);
    finish_run();
  end
endmodule